// File: doc/BRIEF.md
# Serial Port Register Front End with Receive Queue

This block is the register face of a serial port. A host reaches it over a simple 32-bit bus that selects one word per access. Received bytes come in on a byte-wide valid/ready stream and wait in a queue of up to sixteen entries. Each host write to the data word sends one byte out on a transmit strobe. Bit timing and the line shifter sit outside the block. The block holds the divisor, line, control, level, mask and DMA-control settings. It keeps a raw interrupt word, exposes a masked view of it, and drives one interrupt line. A fixed identification window sits at the top of the 4 KiB space.

The queue has two modes, chosen by bit 4 of the line register. When the bit is set, the queue holds sixteen bytes. When it is clear, the queue holds one byte. Changing that bit empties the queue.

Receive stream rules: a byte moves when `rx_valid` and `rx_ready` are both high at a rising edge. `rx_ready` is high only while the queue holds fewer bytes than the active depth and no flush is happening in that cycle. A source that drops its byte while `rx_ready` is low loses that byte. The transmit side has no back-pressure: `tx_valid` is a one-cycle pulse, and the sink must take every pulse.

Top module: `serial_regbank`

## Requirements
- R1: After reset, word 6 (flags) reads 0x90, word 12 (control) reads 0x300 and word 13 (level) reads 0x12. Every other register reads 0. `irq` is low and `rx_ready` is high.
- R2: The storage registers read back the written value cut to their width: word 8 (8 bits), 9 (16), 10 (6), 11 (8), 12 (16), 13 (6), 14 (11) and 18 (3). Writes to words 6, 15 and 16 change nothing. Unmapped words read 0 and ignore writes.
- R3: Received bytes are read from word 0 in arrival order, one byte per read, in bits 7:0. A read of word 0 with the queue empty returns 0.
- R4: Flag bit 4 is high exactly when the queue is empty and bit 7 always reads 1. Flag bit 6 sets when a byte is accepted while line bit 4 is 0, or when an accepted byte brings the fill to 16. Flag bit 6 clears on a read of word 0.
- R5: The fill never exceeds the active depth: 16 when line bit 4 is 1, otherwise 1. `rx_ready` is low at that fill, and a beat offered then is not taken.
- R6: A write to word 11 that flips bit 4 empties the queue and clears flag bit 6. A write to word 11 that leaves bit 4 unchanged keeps the queued bytes.
- R7: Raw bit 4 (word 15) sets when a byte is accepted. It clears on a read of word 0 that leaves the queue empty. The receive trigger level is fixed at 1.
- R8: A write to word 0 drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to bits 7:0 of the written word. The same write sets raw bit 5.
- R9: Word 16 reads the raw word ANDed with word 14. `irq` is high exactly when that result is nonzero. A write to word 17 clears each raw bit that is set in the written value. A set event in the same cycle wins over the clear.
- R10: Word indices 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R11: Word 1 (receive status) always reads 0. Writes to it have no visible effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset; bits 11:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte can be taken |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt, high while any masked bit is set |

## Verification
The checker assumes the receive source follows the handshake: a beat counts only when `rx_ready` is high. The checker also assumes the bus presents one access per cycle, with no partial-word writes. The bench drives every input at the falling edge. It offers receive bytes only in cycles with no data-word read, so the fill steps are unambiguous. It never sends a receive byte and a clear write in the same cycle. Flag, status and interrupt values are read back through the bus only after the edge that updates them.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam int unsigned BW = 8;
  localparam int unsigned IW = AW - 2;

  localparam logic [IW-1:0] IX_DATA   = IW'(0);
  localparam logic [IW-1:0] IX_STAT   = IW'(1);
  localparam logic [IW-1:0] IX_FLAG   = IW'(6);
  localparam logic [IW-1:0] IX_LPDIV  = IW'(8);
  localparam logic [IW-1:0] IX_IDIV   = IW'(9);
  localparam logic [IW-1:0] IX_FDIV   = IW'(10);
  localparam logic [IW-1:0] IX_LINE   = IW'(11);
  localparam logic [IW-1:0] IX_CTRL   = IW'(12);
  localparam logic [IW-1:0] IX_LEVEL  = IW'(13);
  localparam logic [IW-1:0] IX_MASK   = IW'(14);
  localparam logic [IW-1:0] IX_RAW    = IW'(15);
  localparam logic [IW-1:0] IX_MASKED = IW'(16);
  localparam logic [IW-1:0] IX_CLEAR  = IW'(17);
  localparam logic [IW-1:0] IX_DMA    = IW'(18);
  localparam logic [IW-1:0] IX_ID_LO  = IW'(10'h3F8);

  localparam int unsigned W_LPDIV = 8;
  localparam int unsigned W_IDIV  = 16;
  localparam int unsigned W_FDIV  = 6;
  localparam int unsigned W_LINE  = 8;
  localparam int unsigned W_CTRL  = 16;
  localparam int unsigned W_LEVEL = 6;
  localparam int unsigned W_MASK  = 11;
  localparam int unsigned W_DMA   = 3;

  localparam logic [W_CTRL-1:0]  CTRL_RST  = W_CTRL'(16'h0300);
  localparam logic [W_LEVEL-1:0] LEVEL_RST = W_LEVEL'(6'h12);

  localparam int unsigned QEN_BIT = 4;
  localparam int unsigned INT_RX  = 4;
  localparam int unsigned INT_TX  = 5;
  localparam int unsigned FL_EMPTY = 4;
  localparam int unsigned FL_FULL  = 6;
  localparam int unsigned FL_TXE   = 7;

  function automatic logic [BW-1:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/sr_cfg_reg.sv
module sr_cfg_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/sr_rx_queue.sv
module sr_rx_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          pop_ok;

  assign pop_ok = pop && (fill != '0);
  assign head   = (fill != '0) ? mem[rp] : '0;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push)   wp <= nxt(wp);
      if (pop_ok) rp <= nxt(rp);
      fill <= fill + CW'(push) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= push_data;
  end
endmodule

// File: rtl/sr_irq_ctrl.sv
module sr_irq_ctrl #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] mask,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr_vec) | set_vec;
  end
  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import serial_regbank_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned RX_TRIG = 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [BW-1:0] rx_data,
  output logic          tx_valid,
  output logic [BW-1:0] tx_data,
  output logic          irq
);
  logic [IW-1:0] idx;
  logic wr, rd;
  assign idx = bus_addr[AW-1:2];
  assign wr  = bus_sel && bus_we;
  assign rd  = bus_sel && !bus_we;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:16]};

  logic [W_LPDIV-1:0] lpdiv_q;
  logic [W_IDIV-1:0]  idiv_q;
  logic [W_FDIV-1:0]  fdiv_q;
  logic [W_LINE-1:0]  line_q;
  logic [W_CTRL-1:0]  ctrl_q;
  logic [W_LEVEL-1:0] level_q;
  logic [W_MASK-1:0]  mask_q;
  logic [W_DMA-1:0]   dma_q;

  sr_cfg_reg #(.W(W_LPDIV)) u_lpdiv (.clk, .rst_n, .we(wr && idx == IX_LPDIV),
    .d(bus_wdata[W_LPDIV-1:0]), .q(lpdiv_q));
  sr_cfg_reg #(.W(W_IDIV)) u_idiv (.clk, .rst_n, .we(wr && idx == IX_IDIV),
    .d(bus_wdata[W_IDIV-1:0]), .q(idiv_q));
  sr_cfg_reg #(.W(W_FDIV)) u_fdiv (.clk, .rst_n, .we(wr && idx == IX_FDIV),
    .d(bus_wdata[W_FDIV-1:0]), .q(fdiv_q));
  sr_cfg_reg #(.W(W_LINE)) u_line (.clk, .rst_n, .we(wr && idx == IX_LINE),
    .d(bus_wdata[W_LINE-1:0]), .q(line_q));
  sr_cfg_reg #(.W(W_CTRL), .RST(CTRL_RST)) u_ctrl (.clk, .rst_n, .we(wr && idx == IX_CTRL),
    .d(bus_wdata[W_CTRL-1:0]), .q(ctrl_q));
  sr_cfg_reg #(.W(W_LEVEL), .RST(LEVEL_RST)) u_level (.clk, .rst_n, .we(wr && idx == IX_LEVEL),
    .d(bus_wdata[W_LEVEL-1:0]), .q(level_q));
  sr_cfg_reg #(.W(W_MASK)) u_mask (.clk, .rst_n, .we(wr && idx == IX_MASK),
    .d(bus_wdata[W_MASK-1:0]), .q(mask_q));
  sr_cfg_reg #(.W(W_DMA)) u_dma (.clk, .rst_n, .we(wr && idx == IX_DMA),
    .d(bus_wdata[W_DMA-1:0]), .q(dma_q));

  // Receive queue control
  logic          qen, flush, push, pop;
  logic [CW-1:0] rx_count, rx_limit, count_after;
  logic [BW-1:0] head;

  assign qen      = line_q[QEN_BIT];
  assign flush    = wr && (idx == IX_LINE) && (bus_wdata[QEN_BIT] != qen);
  assign rx_limit = qen ? CW'(DEPTH) : CW'(1);
  assign rx_ready = (rx_count < rx_limit) && !flush;
  assign push     = rx_valid && rx_ready;
  assign pop      = rd && (idx == IX_DATA);
  assign count_after = rx_count + CW'(push) - CW'(pop && rx_count != '0);

  sr_rx_queue #(.DEPTH(DEPTH), .W(BW)) u_queue (
    .clk, .rst_n, .flush, .push, .push_data(rx_data), .pop,
    .head, .fill(rx_count)
  );

  logic full_q;
  always_ff @(posedge clk) begin
    if (!rst_n || flush) full_q <= 1'b0;
    else if (push && (!qen || count_after == CW'(DEPTH))) full_q <= 1'b1;
    else if (pop) full_q <= 1'b0;
  end

  // Transmit strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr && (idx == IX_DATA);
      if (wr && idx == IX_DATA) tx_data <= bus_wdata[BW-1:0];
    end
  end

  // Interrupts
  logic [W_MASK-1:0] set_vec, clr_vec, raw_q, masked;
  logic rx_set, rx_clr;
  assign rx_set = push && (count_after >= CW'(RX_TRIG));
  assign rx_clr = pop && (count_after == CW'(RX_TRIG - 1));

  always_comb begin
    set_vec = '0;
    set_vec[INT_RX] = rx_set;
    set_vec[INT_TX] = wr && (idx == IX_DATA);
    clr_vec = (wr && idx == IX_CLEAR) ? bus_wdata[W_MASK-1:0] : '0;
    clr_vec[INT_RX] = clr_vec[INT_RX] | rx_clr;
  end

  sr_irq_ctrl #(.N(W_MASK)) u_irq (
    .clk, .rst_n, .set_vec, .clr_vec, .mask(mask_q),
    .raw(raw_q), .masked, .irq
  );

  // Read mux
  logic [DW-1:0] flags;
  always_comb begin
    flags = '0;
    flags[FL_TXE]   = 1'b1;
    flags[FL_FULL]  = full_q;
    flags[FL_EMPTY] = (rx_count == '0);
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (idx >= IX_ID_LO) bus_rdata = DW'(id_byte(idx[2:0]));
      else begin
        case (idx)
          IX_DATA:   bus_rdata = DW'(head);
          IX_FLAG:   bus_rdata = flags;
          IX_LPDIV:  bus_rdata = DW'(lpdiv_q);
          IX_IDIV:   bus_rdata = DW'(idiv_q);
          IX_FDIV:   bus_rdata = DW'(fdiv_q);
          IX_LINE:   bus_rdata = DW'(line_q);
          IX_CTRL:   bus_rdata = DW'(ctrl_q);
          IX_LEVEL:  bus_rdata = DW'(level_q);
          IX_MASK:   bus_rdata = DW'(mask_q);
          IX_RAW:    bus_rdata = DW'(raw_q);
          IX_MASKED: bus_rdata = DW'(masked);
          IX_DMA:    bus_rdata = DW'(dma_q);
          default:   bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
  parameter int unsigned CW = 5,
  parameter int unsigned MW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [11:0]   bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          irq,
  input logic [CW-1:0] count,
  input logic [CW-1:0] limit,
  input logic [MW-1:0] raw,
  input logic [MW-1:0] mask
);
  logic dwr, drd;
  assign dwr = bus_sel && bus_we && (bus_addr[11:2] == 10'd0);
  assign drd = bus_sel && !bus_we && (bus_addr[11:2] == 10'd0);

  logic unused_chk;
  assign unused_chk = ^{bus_wdata[31:8], bus_addr[1:0]};

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit);
  a_r5_ready_low_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (count == limit) |-> !rx_ready);
  a_r3_fill_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !drd) |=> (count == $past(count) + CW'(1)));
  a_r7_rx_int_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> raw[4]);
  a_r8_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dwr |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));
  a_r8_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dwr |=> !tx_valid);
  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));
endmodule

bind serial_regbank sr_checker #(.CW(CW), .MW(serial_regbank_pkg::W_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq),
  .count(rx_count), .limit(rx_limit), .raw(raw_q), .mask(mask_q)
);

// File: tb/serial_regbank_test.sv
`timescale 1ns/1ps
module serial_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic tx_valid, irq;
  logic [7:0] tx_data;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  serial_regbank uut (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .rx_valid, .rx_ready, .rx_data, .tx_valid, .tx_data, .irq);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic offer(input logic [7:0] b, output logic took);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    #1 took = rx_ready;
    @(negedge clk);
    rx_valid = 0;
  endtask

  // {addr, write data, expected readback}
  localparam logic [75:0] VEC [11] = '{
    {12'h020, 32'hFFFF_FFAB, 32'h0000_00AB},   // R2
    {12'h024, 32'h1234_5678, 32'h0000_5678},   // R2
    {12'h028, 32'h0000_00FF, 32'h0000_003F},   // R2
    {12'h030, 32'hFFFF_0201, 32'h0000_0201},   // R2
    {12'h034, 32'hFFFF_FF2D, 32'h0000_002D},   // R2
    {12'h048, 32'h0000_000F, 32'h0000_0007},   // R2
    {12'h018, 32'h0000_0000, 32'h0000_0090},   // R2 flags ignore writes
    {12'h03C, 32'h0000_00FF, 32'h0000_0000},   // R2 raw ignores writes
    {12'h040, 32'h0000_00FF, 32'h0000_0000},   // R2 masked ignores writes
    {12'h00C, 32'hFFFF_FFFF, 32'h0000_0000},   // R2 unmapped
    {12'h004, 32'h0000_00FF, 32'h0000_0000}    // R11
  };

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [7:0] ID [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    logic took;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rdchk("R1 flags", 12'h018, 32'h90);
    rdchk("R1 control", 12'h030, 32'h300);
    rdchk("R1 level", 12'h034, 32'h12);
    rdchk("R1 idiv", 12'h024, 32'h0);
    rdchk("R1 raw", 12'h03C, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);

    foreach (VEC[i]) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rdchk("R2/R11 table", VEC[i][75:64], VEC[i][31:0]);
    end

    // R4/R5/R7 queue disabled: depth 1
    offer(8'h41, took);
    chk("R3 accept", {31'b0, took}, 32'h1);
    rdchk("R4 full in one-byte mode", 12'h018, 32'hC0);
    rdchk("R7 raw rx set", 12'h03C, 32'h10);
    offer(8'h42, took);
    chk("R5 refused at depth 1", {31'b0, took}, 32'h0);
    rdchk("R3 pop", 12'h000, 32'h41);
    rdchk("R4 empty after pop", 12'h018, 32'h90);
    rdchk("R7 raw rx cleared", 12'h03C, 32'h0);
    rdchk("R3 empty read", 12'h000, 32'h0);

    // R6 enable queue
    wr(12'h02C, 32'h10);
    rdchk("R2 line", 12'h02C, 32'h10);
    for (int k = 0; k < 16; k++) begin
      offer(8'h30 + 8'(k), took);
      chk("R5 accept in 16 mode", {31'b0, took}, 32'h1);
      if (k == 14) rdchk("R4 not full at 15", 12'h018, 32'h80);
    end
    rdchk("R4 full at 16", 12'h018, 32'hC0);
    offer(8'hEE, took);
    chk("R5 refused at 16", {31'b0, took}, 32'h0);
    for (int k = 0; k < 16; k++) begin
      rdchk("R3 order", 12'h000, 32'h30 + 32'(k));
      if (k == 0) rdchk("R4 full clears", 12'h018, 32'h80);
    end
    rdchk("R4 empty", 12'h018, 32'h90);
    rdchk("R7 raw rx clear", 12'h03C, 32'h0);

    // R6 same-bit write keeps bytes
    offer(8'h55, took);
    offer(8'h66, took);
    wr(12'h02C, 32'h70);
    rdchk("R6 kept", 12'h000, 32'h55);
    // R6 flip flushes
    wr(12'h02C, 32'h60);
    rdchk("R6 flushed", 12'h018, 32'h90);
    rdchk("R7 raw survives flush", 12'h03C, 32'h10);
    rdchk("R3 empty after flush", 12'h000, 32'h0);
    rdchk("R7 cleared by empty read", 12'h03C, 32'h0);

    // R8 transmit
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 12'h000; bus_wdata = 32'h1234_55AA;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    chk("R8 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R8 tx_data", {24'b0, tx_data}, 32'hAA);
    @(negedge clk);
    chk("R8 single pulse", {31'b0, tx_valid}, 32'h0);
    rdchk("R8 raw tx", 12'h03C, 32'h20);

    // R9 mask and clear
    chk("R9 irq masked off", {31'b0, irq}, 32'h0);
    wr(12'h038, 32'h30);
    chk("R9 irq on", {31'b0, irq}, 32'h1);
    rdchk("R9 masked", 12'h040, 32'h20);
    wr(12'h044, 32'h20);
    chk("R9 irq off", {31'b0, irq}, 32'h0);
    rdchk("R9 raw cleared", 12'h03C, 32'h0);
    offer(8'h77, took);
    rdchk("R9 masked rx", 12'h040, 32'h10);
    chk("R9 irq rx", {31'b0, irq}, 32'h1);
    wr(12'h044, 32'h10);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    rdchk("R3 byte kept after clear", 12'h000, 32'h77);

    // R10 identification
    for (int k = 0; k < 8; k++) begin
      rd(12'hFE0 + 12'(4 * k), v);
      chk("R10 id", v, {24'b0, ID[k]});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule